// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Unit

This block is the execution stage for the second byte of a prefixed instruction in an 8-bit processor core. It is purely combinational. It splits the byte into three fields: a two-bit operation class, a three-bit selector and a three-bit operand index. It then applies one of eight shift, rotate or swap operations, or a single-bit test, clear or set, to an 8-bit operand that the surrounding core has already fetched. It returns the new operand value, the four condition flags, the operand index and a write strobe. The strobe goes either to the register file or to memory.

The core also reuses the shift datapath for its short accumulator-only rotate instructions. For those it raises `acc_form`, which keeps the zero flag clear whatever the result. The core owns operand fetch, memory access and instruction timing.

Top module: `bmu_core`

## Requirements
- R1: The class is `op_byte[7:6]`: 0 is shift/rotate, 1 is bit test, 2 is bit clear, 3 is bit set. For classes 1 to 3, `op_byte[5:3]` gives the bit number.
- R2: In class 0, `op_byte[5:3]` selects the operation: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left (zero fill), 5 arithmetic shift right, 6 nibble swap, 7 logical shift right. The through-carry rotates fill from the incoming carry.
- R3: The flag ports pack Z, N, H, C in bits 3, 2, 1, 0. In class 0, N and H are cleared and Z is set exactly when the result is zero. C takes the bit shifted or rotated out.
- R4: The arithmetic right shift keeps bit 7 as it was. The logical right shift puts zero in bit 7.
- R5: Swap exchanges the upper and lower nibbles and clears C.
- R6: A bit test sets Z when the chosen bit is 0, clears N, sets H and passes C through unchanged. It returns the operand unchanged and raises neither write strobe.
- R7: Bit clear and bit set return the operand with only the chosen bit forced to 0 or 1. They pass all four flags through unchanged.
- R8: `reg_idx` equals `op_byte[2:0]` (0..7 = B, C, D, E, H, L, memory at HL, A). A writing class raises `mem_wr` when the index is 6 and `reg_wr` otherwise.
- R9: With `acc_form` high, Z is forced to 0 in class 0. In classes 1 to 3 it has no effect.
- R10: `reg_wr` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_byte | input | 8 | Second byte of the prefixed instruction |
| operand | input | 8 | Fetched operand value |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| acc_form | input | 1 | Short accumulator rotate form: forces Z to 0 |
| result | output | 8 | Value to write back |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| reg_idx | output | 3 | Operand index for writeback |
| reg_wr | output | 1 | Register-file write strobe |
| mem_wr | output | 1 | Memory write strobe (index 6) |

## Verification
Two rules can apply to the same byte at once. The accumulator-form zero override can collide with a shift whose result really is zero, and the memory index can collide with the no-writeback rule of the bit test. The bench provokes both by sweeping every op byte with operands that include 0x00, 0x80 and 0x01, with `acc_form` and the incoming carry each at both levels. In every cycle it compares result, flags and both strobes with a behavioural model. For those collisions, the model expects Z at 0 and no strobe at all.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_CLEAR = 2'd2,
    CLS_SETB  = 2'd3
  } op_class_e;

  typedef enum logic [2:0] {
    SK_ROL_C = 3'd0,
    SK_ROR_C = 3'd1,
    SK_ROL_T = 3'd2,
    SK_ROR_T = 3'd3,
    SK_SHL_Z = 3'd4,
    SK_SHR_A = 3'd5,
    SK_SWAP  = 3'd6,
    SK_SHR_L = 3'd7
  } shift_kind_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam logic [2:0] MEM_IDX = 3'd6;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [7:0]  op_byte,
  output op_class_e   cls,
  output logic [2:0]  sel,
  output logic [2:0]  idx
);

  always_comb begin
    cls = op_class_e'(op_byte[7:6]);
    sel = op_byte[5:3];
    idx = op_byte[2:0];
  end

endmodule

// File: rtl/bmu_shifter.sv
module bmu_shifter
  import bmu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  shift_kind_e  kind,
  input  logic         cin,
  output logic [W-1:0] dout,
  output logic         cout
);

  localparam int HALF = W / 2;

  always_comb begin
    dout = din;
    cout = 1'b0;
    unique case (kind)
      SK_ROL_C: begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
      SK_ROR_C: begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
      SK_ROL_T: begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
      SK_ROR_T: begin dout = {cin, din[W-1:1]};      cout = din[0];   end
      SK_SHL_Z: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
      SK_SHR_A: begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
      SK_SWAP:  begin dout = {din[HALF-1:0], din[W-1:HALF]}; cout = 1'b0; end
      default:  begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
    endcase
  end

  // R5: swap never produces a carry
  always_comb begin
    if (kind == SK_SWAP)
      p_swap_no_carry_r5: assert (cout == 1'b0) else $error("swap carry set");
  end

  // R4: arithmetic right shift keeps the top bit
  always_comb begin
    if (kind == SK_SHR_A)
      p_sra_keeps_msb_r4: assert (dout[W-1] == din[W-1]) else $error("sra msb lost");
  end

endmodule

// File: rtl/bmu_bitops.sv
module bmu_bitops #(
  parameter int W = 8
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] bit_no,
  output logic [W-1:0]         cleared,
  output logic [W-1:0]         setv,
  output logic                 tbit
);

  localparam int IDX_W = $clog2(W);

  logic [W-1:0] mask;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (bit_no == IDX_W'(g));
  end

  always_comb begin
    cleared = din & ~mask;
    setv    = din | mask;
    tbit    = |(din & mask);
  end

  // R7: clear and set touch at most one bit
  always_comb begin
    p_single_bit_change_r7: assert ($countones(cleared ^ setv) == 1)
      else $error("bit op changed more than one bit");
  end

endmodule

// File: rtl/bmu_core.sv
module bmu_core
  import bmu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [7:0]   op_byte,
  input  logic [W-1:0] operand,
  input  logic [3:0]   flags_in,
  input  logic         acc_form,
  output logic [W-1:0] result,
  output logic [3:0]   flags_out,
  output logic [2:0]   reg_idx,
  output logic         reg_wr,
  output logic         mem_wr
);

  localparam int IDX_W = $clog2(W);

  op_class_e    cls;
  logic [2:0]   sel;
  logic [2:0]   idx;
  logic [W-1:0] sh_res;
  logic         sh_cout;
  logic [W-1:0] clr_res;
  logic [W-1:0] set_res;
  logic         tbit;
  flags_t       fin;
  flags_t       fnext;
  logic         wb;

  assign fin = flags_t'(flags_in);

  bmu_decode u_dec (
    .op_byte (op_byte),
    .cls     (cls),
    .sel     (sel),
    .idx     (idx)
  );

  bmu_shifter #(.W(W)) u_sh (
    .din  (operand),
    .kind (shift_kind_e'(sel)),
    .cin  (fin.c),
    .dout (sh_res),
    .cout (sh_cout)
  );

  bmu_bitops #(.W(W)) u_bit (
    .din     (operand),
    .bit_no  (sel[IDX_W-1:0]),
    .cleared (clr_res),
    .setv    (set_res),
    .tbit    (tbit)
  );

  always_comb begin
    result = operand;
    fnext  = fin;
    wb     = 1'b0;
    unique case (cls)
      CLS_SHIFT: begin
        result  = sh_res;
        fnext.z = (sh_res == '0) && !acc_form;
        fnext.n = 1'b0;
        fnext.h = 1'b0;
        fnext.c = sh_cout;
        wb      = 1'b1;
      end
      CLS_TEST: begin
        result  = operand;
        fnext.z = !tbit;
        fnext.n = 1'b0;
        fnext.h = 1'b1;
        wb      = 1'b0;
      end
      CLS_CLEAR: begin
        result = clr_res;
        wb     = 1'b1;
      end
      default: begin
        result = set_res;
        wb     = 1'b1;
      end
    endcase
  end

  always_comb begin
    flags_out = fnext;
    reg_idx   = idx;
    reg_wr    = wb && (idx != MEM_IDX);
    mem_wr    = wb && (idx == MEM_IDX);
  end

  // R10: one writeback target at most
  always_comb begin
    p_one_target_r10: assert (!(reg_wr && mem_wr)) else $error("both strobes");
  end

  // R6: a bit test writes nothing and keeps carry
  always_comb begin
    if (op_byte[7:6] == 2'd1) begin
      p_test_no_write_r6: assert (!reg_wr && !mem_wr) else $error("test wrote");
      p_test_keeps_c_r6:  assert (flags_out[0] == flags_in[0]) else $error("test changed C");
    end
  end

  // R7: clear and set preserve flags
  always_comb begin
    if (op_byte[7] == 1'b1)
      p_bitop_flags_r7: assert (flags_out == flags_in) else $error("bit op changed flags");
  end

  // R3 and R9: shift class clears N/H, accumulator form has Z low
  always_comb begin
    if (op_byte[7:6] == 2'd0) begin
      p_shift_nh_clear_r3: assert (flags_out[2:1] == 2'b00) else $error("N/H set");
      if (acc_form)
        p_acc_zero_low_r9: assert (flags_out[3] == 1'b0) else $error("Z set in acc form");
    end
  end

endmodule

// File: tb/tb_bmu_core.sv
module tb_bmu_core;

  logic       clk;
  logic       rst_n;
  logic [7:0] op_byte;
  logic [7:0] operand;
  logic [3:0] flags_in;
  logic       acc_form;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic [2:0] reg_idx;
  logic       reg_wr;
  logic       mem_wr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bmu_core dut (
    .op_byte   (op_byte),
    .operand   (operand),
    .flags_in  (flags_in),
    .acc_form  (acc_form),
    .result    (result),
    .flags_out (flags_out),
    .reg_idx   (reg_idx),
    .reg_wr    (reg_wr),
    .mem_wr    (mem_wr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference, integer arithmetic
  task automatic model(input int op, input int v, input int fl, input int acc,
                       output int r, output int fo, output int rw, output int mw);
    int cls, s, ix, cin, co, z, n, h, c, wr;
    cls = op / 64; s = (op / 8) % 8; ix = op % 8; cin = fl % 2;
    z = (fl / 8) % 2; n = (fl / 4) % 2; h = (fl / 2) % 2; c = cin;
    r = v; wr = 1; co = 0;
    if (cls == 0) begin
      case (s)
        0: begin r = ((v * 2) + (v / 128)) % 256; co = v / 128; end
        1: begin r = (v / 2) + (v % 2) * 128;     co = v % 2;   end
        2: begin r = ((v * 2) + cin) % 256;       co = v / 128; end
        3: begin r = (v / 2) + cin * 128;         co = v % 2;   end
        4: begin r = (v * 2) % 256;               co = v / 128; end
        5: begin r = (v / 2) + (v / 128) * 128;   co = v % 2;   end
        6: begin r = (v % 16) * 16 + (v / 16);    co = 0;       end
        default: begin r = v / 2;                 co = v % 2;   end
      endcase
      z = (r == 0 && acc == 0) ? 1 : 0; n = 0; h = 0; c = co;
    end else if (cls == 1) begin
      z = ((v >> s) % 2 == 0) ? 1 : 0; n = 0; h = 1; wr = 0;
    end else if (cls == 2) begin
      r = v & ~(1 << s) & 255;
    end else begin
      r = v | (1 << s);
    end
    fo = z * 8 + n * 4 + h * 2 + c;
    rw = (wr == 1 && ix != 6) ? 1 : 0;
    mw = (wr == 1 && ix == 6) ? 1 : 0;
  endtask

  task automatic run(input int op, input int v, input int fl, input int acc, input string tag);
    int r, fo, rw, mw;
    @(posedge clk);
    op_byte = 8'(op); operand = 8'(v); flags_in = 4'(fl); acc_form = acc[0];
    model(op, v, fl, acc, r, fo, rw, mw);
    @(negedge clk);
    total++;
    if (result !== 8'(r) || flags_out !== 4'(fo) || reg_wr !== rw[0] || mem_wr !== mw[0]
        || reg_idx !== 3'(op % 8)) begin
      bad++;
      $display("FAIL %s op=%02h v=%02h fl=%h acc=%0d: got r=%02h f=%h rw=%b mw=%b ix=%0d exp r=%02h f=%h rw=%0d mw=%0d ix=%0d",
               tag, op, v, fl, acc, result, flags_out, reg_wr, mem_wr, reg_idx,
               r, fo, rw, mw, op % 8);
    end
  endtask

  function automatic string tag_of(int op);
    int cls, s;
    cls = op / 64; s = (op / 8) % 8;
    if (cls == 1) return "R6";
    if (cls >= 2) return "R7";
    if (s == 5 || s == 7) return "R4";
    if (s == 6) return "R5";
    return "R2";
  endfunction

  initial begin
    rst_n = 1'b0;
    op_byte = '0; operand = '0; flags_in = '0; acc_form = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R3: initial idle pattern, zero rotate sets Z
    run(8'h00, 8'h00, 4'h0, 0, "R3");
    // R1: class decode
    run(8'h40, 8'h01, 4'h1, 0, "R1");
    run(8'hC0, 8'h00, 4'h0, 0, "R1");
    // R2: through-carry rotates use incoming carry
    run(8'h10, 8'h80, 4'h1, 0, "R2");
    run(8'h18, 8'h01, 4'h0, 0, "R2");
    // R4: arithmetic vs logical right shift
    run(8'h28, 8'h81, 4'h0, 0, "R4");
    run(8'h38, 8'h81, 4'h0, 0, "R4");
    // R5: swap clears carry
    run(8'h30, 8'hA5, 4'h1, 0, "R5");
    // R6: bit test on memory index: no strobe, C kept
    run(8'h7E, 8'h00, 4'h1, 0, "R6");
    // R7: clear/set keep flags
    run(8'hBF, 8'hFF, 4'hA, 0, "R7");
    run(8'hC7, 8'h00, 4'h5, 0, "R7");
    // R8: memory index routes to mem_wr
    run(8'h06, 8'h42, 4'h0, 0, "R8");
    run(8'hF6, 8'h00, 4'h0, 0, "R8");
    // R9: acc form forces Z low even on zero result, no effect on test
    run(8'h17, 8'h80, 4'h0, 1, "R9");
    run(8'h47, 8'h00, 4'h0, 1, "R9");
    // R10 and full sweep
    for (int op = 0; op < 256; op++) begin
      for (int k = 0; k < 6; k++) begin
        for (int f = 0; f < 2; f++) begin
          for (int a = 0; a < 2; a++) begin
            int v;
            case (k)
              0: v = 8'h00; 1: v = 8'h80; 2: v = 8'h01;
              3: v = 8'hFF; 4: v = 8'h5A; default: v = (op * 37 + 11) % 256;
            endcase
            run(op, v, f == 0 ? 4'h0 : 4'hF, a, a == 1 ? "R9" : (op % 8 == 6 ? "R10" : tag_of(op)));
          end
        end
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule